// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a 32-bit streaming input into system memory through a ring of descriptors that software owns and recycles. Each descriptor is 16 bytes. Its first word holds the address of a 2048-byte receive buffer, and its second word is a status word that the engine fills in when a frame has landed. For every frame, the engine fetches the buffer address of the current descriptor. It then writes the frame's beats into that buffer in order and, as a final step, writes one status word that carries the done flag and the byte length.

Software hands descriptors back by writing the index of the last descriptor it has released into a release-index register. The engine owns every descriptor from its own fill index up to, but not including, the release index. When the two indices are equal the ring is full, and the input stream is held off until software releases more. At start-up, software writes the release index as count minus one, which gives all but one descriptor to the engine. Frames that exceed the buffer are cut at 2048 bytes and their remaining beats are discarded.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, all registers read zero, `s_tready` is low and `mem_req` is low.
- R2: To start a frame, the engine reads the buffer address at `base + 16*idx`, where idx is the fill index. Beat k of the frame is then written to `buffer + 4*k`, with byte 0 of the stream in bits 7:0.
- R3: Once the last stored data write has finished, the engine writes one status word to `base + 16*idx + 4`. It has bit 31 (done) set, bit 30 (last segment) set, the byte length in bits 29:16, and every other bit zero. No data write of that frame follows it.
- R4: Every beat except the last counts 4 bytes. The last beat (`s_tlast` high) counts the number of ones in `s_tkeep`, whose bytes are contiguous from bit 0.
- R5: Beats that would land at buffer offset 2048 or beyond are accepted from the stream but not written. The recorded length is at most 2048.
- R6: `s_tready` stays low while no frame is in progress and the fill index equals the release index. A frame starts once software writes a different release index.
- R7: After a frame completes, the fill index advances by one, and it wraps from count-1 to 0.
- R8: In the config word at 0x204, bit 2 enables the engine. While bit 2 is clear no new frame starts. Bit 3 is read-only and reads 1 while a frame is in progress.
- R9: Writing 1 to bit 16 of the register at 0x208 sets the fill index to 0.
- R10: The ring base at 0x100, the descriptor count at 0x104 and the release index at 0x108 read back the values written to them.
- R11: A memory request keeps its address, data and direction stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Stream data, byte 0 in bits 7:0 |
| s_tkeep | input | 4 | Valid bytes of the last beat |
| s_tlast | input | 1 | Marks the last beat of a frame |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Engine accepts a beat |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The bench drives the ring to full and checks that the stream stays stalled until a release. A design that tested the next index instead of the current one would either overrun a descriptor software still holds or waste a slot. It sends a frame longer than a buffer and checks the word just beyond the buffer and the capped length, which catches a design that overwrites the neighbouring buffer or reports the raw byte count. It also covers partial last beats, the wrap from the top descriptor back to 0, index reset and a slow memory. These catch, in turn, wrong length arithmetic, a missing wrap, a stale fill index, and a request whose address drifts before it is acknowledged.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] s_tdata,
  input  logic [3:0]  s_tkeep,
  input  logic        s_tlast,
  input  logic        s_tvalid,
  output logic        s_tready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int OFF_W = $clog2(BUF_BYTES) + 1;
  localparam int LEN_W = 14;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DATA, S_WR, S_DESC} state_t;
  state_t state;

  logic [31:0]      ring_base, desc_q, buf_q, word_q;
  logic [IDX_W:0]   ring_cnt;
  logic [IDX_W-1:0] rel_idx, fill_idx;
  logic             en, last_q;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       beat_bytes;
  logic             busy, can_start, wr_base, wr_cnt, wr_rel, wr_cfg, wr_rst;
  logic [IDX_W:0]   fill_inc;

  assign busy       = (state != S_IDLE);
  assign can_start  = en && s_tvalid && (fill_idx != rel_idx) && (ring_cnt != '0);
  assign fill_inc   = {1'b0, fill_idx} + 1'b1;
  assign beat_bytes = s_tlast ? 3'($countones(s_tkeep)) : 3'd4;

  assign wr_base = reg_we && reg_addr == 12'h100;
  assign wr_cnt  = reg_we && reg_addr == 12'h104;
  assign wr_rel  = reg_we && reg_addr == 12'h108;
  assign wr_cfg  = reg_we && reg_addr == 12'h204;
  assign wr_rst  = reg_we && reg_addr == 12'h208 && reg_wdata[16];

  assign s_tready  = (state == S_DATA);
  assign mem_req   = (state == S_FETCH) || (state == S_WR) || (state == S_DESC);
  assign mem_we    = (state != S_FETCH);
  assign mem_addr  = (state == S_WR)   ? buf_q + 32'(off) :
                     (state == S_DESC) ? desc_q + 32'd4 : desc_q;
  assign mem_wdata = (state == S_DESC) ? {2'b11, len_q, 16'h0000} : word_q;

  always_comb begin
    case (reg_addr)
      12'h100: reg_rdata = ring_base;
      12'h104: reg_rdata = 32'(ring_cnt);
      12'h108: reg_rdata = 32'(rel_idx);
      12'h204: reg_rdata = {28'd0, busy, en, 2'b00};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      ring_cnt  <= '0;
      rel_idx   <= '0;
      en        <= 1'b0;
    end else begin
      if (wr_base) ring_base <= reg_wdata;
      if (wr_cnt)  ring_cnt  <= reg_wdata[IDX_W:0];
      if (wr_rel)  rel_idx   <= reg_wdata[IDX_W-1:0];
      if (wr_cfg)  en        <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fill_idx <= '0;
      desc_q   <= '0;
      buf_q    <= '0;
      word_q   <= '0;
      last_q   <= 1'b0;
      off      <= '0;
      len_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (can_start) begin
          desc_q <= ring_base + {{(28-IDX_W){1'b0}}, fill_idx, 4'b0000};
          off    <= '0;
          len_q  <= '0;
          state  <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_DATA;
        end
        S_DATA: if (s_tvalid) begin
          if (off < OFF_W'(BUF_BYTES)) begin
            word_q <= s_tdata;
            last_q <= s_tlast;
            len_q  <= len_q + LEN_W'(beat_bytes);
            state  <= S_WR;
          end else if (s_tlast) begin
            state <= S_DESC;
          end
        end
        S_WR: if (mem_ack) begin
          off   <= off + OFF_W'(4);
          state <= last_q ? S_DESC : S_DATA;
        end
        S_DESC: if (mem_ack) begin
          fill_idx <= (fill_inc == ring_cnt) ? '0 : fill_inc[IDX_W-1:0];
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (wr_rst) fill_idx <= '0;
    end
  end

  // R11: a request is held unchanged until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5: data writes stay inside the current buffer
  assert_buf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && state == S_WR) |-> ((mem_addr - buf_q) < 32'(BUF_BYTES)));

  // R5: recorded length never exceeds the buffer size
  assert_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && state == S_DESC) |-> (mem_wdata[29:16] <= 14'(BUF_BYTES)));

  // R9: index reset takes effect on the next cycle
  assert_idx_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (fill_idx == '0));

  // R6: no beat is taken when idle with a full ring
  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && fill_idx == rel_idx) |=> !s_tready);
endmodule

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_tdata = '0;
  logic [3:0]  s_tkeep = '0;
  logic        s_tlast = 1'b0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  rx_ring_dma u0 (.*);

  always #4 clk = ~clk;

  logic [31:0] mem [0:4095];
  int  delay = 0, dcnt = 0;
  int  desc_wr = 0, order_err = 0, addr_err = 0;
  int  tests = 0, fails = 0, cycles = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr;

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && pend && mem_addr != pend_addr) addr_err <= addr_err + 1;
    pend      <= mem_req && !mem_ack;
    pend_addr <= mem_addr;
    mem_ack   <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (dcnt < delay) dcnt <= dcnt + 1;
      else begin
        dcnt    <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          if (mem_addr < 32'h40 && mem_addr[3:2] == 2'd1) desc_wr <= desc_wr + 1;
          else if (desc_wr > 0) order_err <= order_err + 1;
        end else mem_rdata <= mem[mem_addr[13:2]];
      end
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] pat(input int f, input int k);
    return {f[7:0], 8'h5A, k[15:0]};
  endfunction

  task automatic send(input int f, input int beats, input logic [3:0] lastkeep, input bit chkbusy);
    logic [31:0] r;
    desc_wr = 0; order_err = 0;
    for (int k = 0; k < beats; k++) begin
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = pat(f, k);
      s_tlast = (k == beats - 1); s_tkeep = (k == beats - 1) ? lastkeep : 4'hF;
      while (!s_tready) @(negedge clk);
      @(posedge clk);
      if (k == 0 && chkbusy) begin
        @(negedge clk); #1 reg_addr = 12'h204; #1 chk("R8 busy during frame", 32'(reg_rdata[3]), 1);
      end
    end
    @(negedge clk); s_tvalid = 1'b0; s_tlast = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rreg(12'h204, r);
      if (!r[3]) break;
    end
    chk("R8 busy clear after frame", 32'(r[3]), 0);
  endtask

  task automatic chk_frame(input string tag, input int f, input int d, input int beats, input int len);
    int bw;
    bw = (32'h1000 + 32'h800 * d) >> 2;
    chk({tag, " R3 status word"}, mem[4*d+1], 32'hC000_0000 | (32'(len) << 16));
    chk({tag, " R3 single status write"}, desc_wr, 1);
    chk({tag, " R3 no data after status"}, order_err, 0);
    chk({tag, " R2 first word"}, mem[bw], pat(f, 0));
    chk({tag, " R2 last stored word"}, mem[bw + ((beats > 512 ? 512 : beats) - 1)],
        pat(f, (beats > 512 ? 512 : beats) - 1));
  endtask

  task automatic expect_stall(input string tag);
    @(negedge clk); s_tvalid = 1'b1; s_tlast = 1'b1; s_tkeep = 4'hF;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_tready) seen++; end
      chk(tag, seen, 0);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    rreg(12'h100, r); chk("R1 base reset", r, 0);
    rreg(12'h104, r); chk("R1 count reset", r, 0);
    rreg(12'h108, r); chk("R1 release reset", r, 0);
    rreg(12'h204, r); chk("R1 cfg reset", r, 0);
    chk("R1 tready reset", 32'(s_tready), 0);
    chk("R1 mem_req reset", 32'(mem_req), 0);
  endtask

  task automatic t_config;
    logic [31:0] r;
    wreg(12'h100, 32'h0); wreg(12'h104, 32'd4); wreg(12'h108, 32'd3); wreg(12'h204, 32'h4);
    rreg(12'h104, r); chk("R10 count readback", r, 4);
    rreg(12'h108, r); chk("R10 release readback", r, 3);
    wreg(12'h100, 32'h0000_1230); rreg(12'h100, r); chk("R10 base readback", r, 32'h1230);
    wreg(12'h100, 32'h0);
  endtask

  task automatic t_basic;
    send(1, 3, 4'hF, 0); chk_frame("R4 full beats", 1, 0, 3, 12);
    send(2, 5, 4'h1, 0); chk_frame("R4 one byte tail", 2, 1, 5, 17);
    send(3, 1, 4'h3, 0); chk_frame("R4 single short beat", 3, 2, 1, 2);
  endtask

  task automatic t_full_wrap;
    expect_stall("R6 stall when ring full");
    wreg(12'h108, 32'd0);
    send(4, 2, 4'h7, 0); chk_frame("R6 resume after release", 4, 3, 2, 7);
    expect_stall("R7 wrapped index meets release");
  endtask

  task automatic t_trunc;
    mem[32'h1800 >> 2] = 32'h5E5E_5E5E;
    wreg(12'h108, 32'd2);
    send(5, 520, 4'hF, 0); chk_frame("R5 R7 truncated in slot 0", 5, 0, 520, 2048);
    chk("R5 neighbour buffer untouched", mem[32'h1800 >> 2], 32'h5E5E_5E5E);
  endtask

  task automatic t_enable;
    wreg(12'h204, 32'h0);
    expect_stall("R8 disabled engine stalls");
    wreg(12'h204, 32'h4);
    send(6, 4, 4'hF, 1); chk_frame("R8 frame after enable", 6, 1, 4, 16);
  endtask

  task automatic t_idx_reset;
    wreg(12'h208, 32'h0001_0000);
    wreg(12'h108, 32'd1);
    delay = 3; addr_err = 0;
    send(7, 6, 4'hF, 0); chk_frame("R9 frame lands in slot 0", 7, 0, 6, 24);
    chk("R11 address stable while waiting", addr_err, 0);
    delay = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'hDEAD_BEEF;
    for (int d = 0; d < 4; d++) begin
      mem[4*d]   = 32'h1000 + 32'h800 * d;
      mem[4*d+1] = 32'h4000_0000;
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_config;
    t_basic;
    t_full_wrap;
    t_trunc;
    t_enable;
    t_idx_reset;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule